// File: doc/BRIEF.md
# Vector Table Lookup Permute Unit

This block performs a per-element table lookup over a vector of `VL` bits. It owns a 32-entry vector register file. A 32-bit instruction word names an index register, a table register and a destination register, and it picks a run-time element width of 8, 16, 32 or 64 bits. The table is either one register or two adjacent registers joined together. Each destination lane takes the table element chosen by the index in the same lane. When that index falls past the end of the table, the lane becomes zero instead of wrapping.

An operation starts with a one-cycle `start` pulse while the unit is idle. The unit holds `busy` for one cycle. It then writes the destination register and pulses `done` in the cycle that the new value becomes readable. An instruction word that matches neither lookup form raises `illegal` for one cycle and leaves the register file untouched. A side write port loads registers while the unit is idle, and a combinational read port shows any register.

Top module: `vec_tbl_unit`

## Requirements
- R1: Instruction bits [23:22] set the element width W = 8 << size (0 bytes, 1 halfwords, 2 words, 3 doublewords). The vector holds VL/W lanes, and each lane is decoded and written at width W.
- R2: Opcode bits [15:10] = 001100 select the single form. Lane e of register Zd (bits [4:0]) becomes element idx of register Zn (bits [9:5]), where idx is lane e of register Zm (bits [20:16]) and idx < VL/W.
- R3: Opcode 001010 selects the double form. The table is register (Zn+1) mod 32 placed above register Zn, so Zn supplies elements 0..VL/W-1. Zn = 31 pairs with register 0.
- R4: Each index is read as an unsigned number of the full width W. An index at or above the table size (VL/W single, 2*VL/W double) yields an all-zero lane.
- R5: All lanes are formed from register values taken before the write, so Zd may equal Zn, Zn+1 or Zm.
- R6: A start with bits [31:24] not 00000101, bit 21 not 1, or an opcode that is neither form raises `illegal` for exactly one cycle. In that case `busy` stays low and no register changes.
- R7: A start taken while idle with a legal word drives `busy` high in the next cycle. `done` pulses for exactly one cycle in the cycle after that, together with the visible Zd write. A `start` seen while busy is ignored.
- R8: A side write (`tb_we`) updates the register in the next cycle when the unit is idle, and has no effect while `busy` is high.
- R9: After reset, `busy`, `done` and `illegal` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| instr | input | 32 | Instruction word, sampled with start |
| tb_we | input | 1 | Side write enable |
| tb_waddr | input | 5 | Side write register number |
| tb_wdata | input | VL | Side write data |
| rd_addr | input | 5 | Observation read register number |
| rd_data | output | VL | Observation read data (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: destination written |
| illegal | output | 1 | One-cycle pulse: unrecognised instruction word |

## Verification
The bound checker watches the control timing on every cycle. It checks that an accepted legal start leads to `busy`, that `busy` leads to a single `done`, that a rejected word leads to a single `illegal` with `busy` low, and that `done` and `illegal` never coincide. The lane contents can only be shown by the bench scenarios, which compare whole registers against a reference model. These scenarios cover all four widths, both table forms, indices one below and exactly at the table size, wide indices whose upper bits are set, Zn = 31 wrap-around, and aliased destinations. The bench also shows that starts and side writes issued while busy leave the registers unchanged.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
    localparam int NREG  = 32;
    localparam int RAW   = $clog2(NREG);
    localparam logic [7:0] MAJOR_CODE = 8'b0000_0101;
    localparam logic [5:0] OPC_ONE    = 6'b001100;
    localparam logic [5:0] OPC_TWO    = 6'b001010;

    typedef enum logic {ST_IDLE, ST_EXEC} tbl_state_t;

    typedef struct packed {
        logic [1:0]     size;
        logic           two_reg;
        logic [RAW-1:0] idx_reg;
        logic [RAW-1:0] tab_reg;
        logic [RAW-1:0] dst_reg;
    } tbl_op_t;

    function automatic logic [RAW-1:0] upper_reg(input logic [RAW-1:0] r);
        return r + RAW'(1);
    endfunction
endpackage

// File: rtl/vtbl_decode.sv
module vtbl_decode
    import vtbl_pkg::*;
(
    input  logic [31:0] instr,
    output logic        legal,
    output tbl_op_t     op
);
    logic [5:0] opc;
    logic       hdr_ok;

    always_comb begin
        opc        = instr[15:10];
        hdr_ok     = (instr[31:24] == MAJOR_CODE) && instr[21];
        legal      = hdr_ok && ((opc == OPC_ONE) || (opc == OPC_TWO));
        op.size    = instr[23:22];
        op.two_reg = (opc == OPC_TWO);
        op.idx_reg = instr[20:16];
        op.tab_reg = instr[9:5];
        op.dst_reg = instr[4:0];
    end
endmodule

// File: rtl/vtbl_regfile.sv
module vtbl_regfile
    import vtbl_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [VL-1:0]  wdata,
    input  logic [RAW-1:0] ra_lo,
    input  logic [RAW-1:0] ra_hi,
    input  logic [RAW-1:0] ra_ix,
    input  logic [RAW-1:0] ra_obs,
    output logic [VL-1:0]  rd_lo,
    output logic [VL-1:0]  rd_hi,
    output logic [VL-1:0]  rd_ix,
    output logic [VL-1:0]  rd_obs
);
    logic [VL-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rd_lo  = mem[ra_lo];
    assign rd_hi  = mem[ra_hi];
    assign rd_ix  = mem[ra_ix];
    assign rd_obs = mem[ra_obs];
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup #(
    parameter int VL = 256
) (
    input  logic [1:0]    size,
    input  logic          two_reg,
    input  logic [VL-1:0] tab_lo,
    input  logic [VL-1:0] tab_hi,
    input  logic [VL-1:0] idx_vec,
    output logic [VL-1:0] res
);
    logic [2*VL-1:0] table_bits;
    logic [VL-1:0]   res_by_size [4];

    assign table_bits = {tab_hi, tab_lo};

    for (genvar s = 0; s < 4; s++) begin : g_size
        localparam int W  = 8 << s;
        localparam int NE = VL / W;
        localparam int TE = 2 * NE;
        localparam int IW = $clog2(TE);
        for (genvar e = 0; e < NE; e++) begin : g_lane
            logic [W-1:0]  idx;
            logic [63:0]   idx_wide;
            logic [63:0]   limit;
            logic [W-1:0]  val;
            assign idx = idx_vec[e*W +: W];
            always_comb begin
                idx_wide = 64'(idx);
                limit    = two_reg ? 64'(TE) : 64'(NE);
                if (idx_wide < limit)
                    val = table_bits[int'(idx[IW-1:0]) * W +: W];
                else
                    val = '0;
            end
            assign res_by_size[s][e*W +: W] = val;
        end
    end

    assign res = res_by_size[size];
endmodule

// File: rtl/vec_tbl_unit.sv
module vec_tbl_unit
    import vtbl_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [31:0]   instr,
    input  logic          tb_we,
    input  logic [4:0]    tb_waddr,
    input  logic [VL-1:0] tb_wdata,
    input  logic [4:0]    rd_addr,
    output logic [VL-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          illegal
);
    tbl_state_t    state;
    tbl_op_t       dec_op, op_q;
    logic          dec_legal;
    logic [VL-1:0] tab_lo, tab_hi, idx_vec, lookup_res;
    logic          rf_we;
    logic [4:0]    rf_waddr;
    logic [VL-1:0] rf_wdata;

    vtbl_decode u_dec (
        .instr (instr),
        .legal (dec_legal),
        .op    (dec_op)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (dec_legal) begin
                        op_q  <= dec_op;
                        state <= ST_EXEC;
                    end else begin
                        illegal <= 1'b1;
                    end
                end
                ST_EXEC: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_EXEC);

    always_comb begin
        rf_we    = busy || (tb_we && !busy);
        rf_waddr = busy ? op_q.dst_reg : tb_waddr;
        rf_wdata = busy ? lookup_res   : tb_wdata;
    end

    vtbl_regfile #(.VL(VL)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .ra_lo  (op_q.tab_reg),
        .ra_hi  (upper_reg(op_q.tab_reg)),
        .ra_ix  (op_q.idx_reg),
        .ra_obs (rd_addr),
        .rd_lo  (tab_lo),
        .rd_hi  (tab_hi),
        .rd_ix  (idx_vec),
        .rd_obs (rd_data)
    );

    vtbl_lookup #(.VL(VL)) u_lut (
        .size    (op_q.size),
        .two_reg (op_q.two_reg),
        .tab_lo  (tab_lo),
        .tab_hi  (tab_hi),
        .idx_vec (idx_vec),
        .res     (lookup_res)
    );
endmodule

// File: rtl/vtbl_chk.sv
module vtbl_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] instr,
    input logic        busy,
    input logic        done,
    input logic        illegal
);
    logic word_ok;
    assign word_ok = (instr[31:24] == 8'h05) && instr[21] &&
                     ((instr[15:10] == 6'b001100) || (instr[15:10] == 6'b001010));

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && word_ok) |=> (busy && !illegal));

    p_busy_to_done_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done && !busy));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !word_ok) |=> (illegal && !busy));

    p_illegal_single_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !illegal);

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !done);
endmodule

bind vec_tbl_unit vtbl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .instr   (instr),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
);

// File: tb/test_vec_tbl_unit.sv
module test_vec_tbl_unit;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   instr;
    logic          tb_we;
    logic [4:0]    tb_waddr;
    logic [VL-1:0] tb_wdata;
    logic [4:0]    rd_addr;
    logic [VL-1:0] rd_data;
    logic          busy, done, illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [VL-1:0] model [32];

    always #4 clk = ~clk;

    vec_tbl_unit #(.VL(VL)) i_vec_tbl_unit (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .tb_we(tb_we), .tb_waddr(tb_waddr), .tb_wdata(tb_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req,
                         input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int sz, input bit two,
                                       input int zm, input int zn, input int zd);
        return {8'h05, 2'(sz), 1'b1, 5'(zm), two ? 6'b001010 : 6'b001100, 5'(zn), 5'(zd)};
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    function automatic logic [VL-1:0] ref_tbl(input int sz, input bit two,
            input logic [VL-1:0] lo, input logic [VL-1:0] hi, input logic [VL-1:0] iv);
        int W = 8 << sz;
        int NE = VL / W;
        longint unsigned lim = two ? 2*NE : NE;
        logic [2*VL-1:0] t = {hi, lo};
        logic [VL-1:0] r = '0;
        for (int e = 0; e < NE; e++) begin
            logic [63:0] ix = '0;
            for (int b = 0; b < W; b++) ix[b] = iv[e*W + b];
            if (ix < lim)
                for (int b = 0; b < W; b++) r[e*W + b] = t[int'(ix)*W + b];
        end
        return r;
    endfunction

    // index vector: mode 0 random near boundary, mode 1 directed boundary
    function automatic logic [VL-1:0] idx_vec(input int sz, input bit two, input int mode);
        int W = 8 << sz;
        int NE = VL / W;
        int lim = two ? 2*NE : NE;
        logic [VL-1:0] v = '0;
        for (int e = 0; e < NE; e++) begin
            logic [63:0] x;
            if (mode == 1) begin
                case (e % 4)
                    0: x = 64'(lim - 1);
                    1: x = 64'(lim);
                    2: x = 64'(0);
                    default: x = 64'(e % lim);
                endcase
            end else if ($urandom % 8 == 0) begin
                x = {$urandom(), $urandom()};
            end else begin
                x = 64'($urandom % (lim + 3));
            end
            for (int b = 0; b < W; b++) v[e*W + b] = x[b];
        end
        return v;
    endfunction

    task automatic load(input int r, input logic [VL-1:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = 5'(r); tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
        model[r] = d;
    endtask

    task automatic run_op(input int sz, input bit two, input int zm, input int zn,
                          input int zd, input bit disturb, input string req);
        logic [VL-1:0] exp;
        int zd2, wr2;
        logic [VL-1:0] junk;
        exp = ref_tbl(sz, two, model[zn], model[(zn+1) % 32], model[zm]);
        zd2 = (zd + 1) % 32;
        wr2 = (zd + 2) % 32;
        junk = rnd_vec();
        @(negedge clk);
        start = 1'b1; instr = mk(sz, two, zm, zn, zd);
        @(negedge clk);
        check(busy && !done, "R7 busy after start", {255'b0, busy}, 1);
        if (disturb) begin
            start = 1'b1; instr = mk(0, 0, zm, zn, zd2);
            tb_we = 1'b1; tb_waddr = 5'(wr2); tb_wdata = junk;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0; tb_we = 1'b0;
        rd_addr = 5'(zd);
        #1;
        check(done && !busy, "R7 done pulse", {255'b0, done}, 1);
        check(rd_data === exp, req, rd_data, exp);
        model[zd] = exp;
        @(negedge clk);
        check(!done && !busy, "R7 done one cycle", {255'b0, done}, 0);
        if (disturb) begin
            rd_addr = 5'(wr2); #1;
            check(rd_data === model[wr2], "R8 write ignored while busy", rd_data, model[wr2]);
            rd_addr = 5'(zd2); #1;
            check(rd_data === model[zd2], "R7 start ignored while busy", rd_data, model[zd2]);
        end
    endtask

    task automatic run_bad(input logic [31:0] w, input int zd);
        @(negedge clk);
        start = 1'b1; instr = w;
        @(negedge clk);
        start = 1'b0;
        rd_addr = 5'(zd); #1;
        check(illegal && !busy, "R6 illegal raised", {255'b0, illegal}, 1);
        check(rd_data === model[zd], "R6 no write", rd_data, model[zd]);
        @(negedge clk);
        check(!illegal && !done, "R6 illegal one cycle", {255'b0, illegal}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; start = 1'b0; instr = '0; tb_we = 1'b0;
        tb_waddr = '0; tb_wdata = '0; rd_addr = 5'd5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !illegal, "R9 reset outputs", {253'b0, busy, done, illegal}, 0);
        check(rd_data === '0, "R9 register zero", rd_data, '0);

        for (int r = 0; r < 32; r++) load(r, rnd_vec());
        rd_addr = 5'd17; #1;
        check(rd_data === model[17], "R8 idle side write", rd_data, model[17]);

        // directed boundary per width and form (R1 R2 R3 R4)
        for (int sz = 0; sz < 4; sz++) begin
            for (int two = 0; two < 2; two++) begin
                load(3, idx_vec(sz, two[0], 1));
                run_op(sz, two[0], 3, 7, 10, 0, two ? "R3 double boundary" : "R2 single boundary");
                run_op(sz, two[0], 3, 31, 11, 0, "R4 zn31 boundary lanes");
            end
            load(4, idx_vec(sz, 1, 0));
            run_op(sz, 1, 4, 31, 12, 0, "R3 zn31 wraps to r0");
            run_op(sz, 0, 4, 20, 13, 0, "R1 width select");
        end

        // aliasing (R5)
        load(6, idx_vec(1, 1, 0));
        run_op(1, 1, 6, 8, 8, 0, "R5 zd equals zn");
        load(6, idx_vec(2, 1, 0));
        run_op(2, 1, 6, 8, 9, 0, "R5 zd equals zn+1");
        load(6, idx_vec(0, 0, 0));
        run_op(0, 0, 6, 14, 6, 0, "R5 zd equals zm");

        // illegal words (R6)
        run_bad(32'h0000_0000, 2);
        run_bad(mk(0, 0, 1, 2, 3) & ~32'h0020_0000, 3);
        run_bad((mk(1, 0, 1, 2, 4) & ~32'h0000_FC00) | 32'h0000_2C00, 4);
        run_bad(mk(2, 1, 1, 2, 5) ^ 32'h8000_0000, 5);

        // start and side write while busy (R7 R8)
        load(4, idx_vec(0, 1, 0));
        run_op(0, 1, 4, 16, 20, 1, "R7 disturbed op result");
        load(4, idx_vec(3, 0, 0));
        run_op(3, 0, 4, 18, 25, 1, "R7 disturbed op result");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int sz = $urandom % 4;
            bit two = 1'($urandom);
            int zm = $urandom % 32;
            int zn = $urandom % 32;
            int zd = $urandom % 32;
            if ($urandom % 4 != 0) load(zm, idx_vec(sz, two, 0));
            if ($urandom % 16 == 0) load(zn, rnd_vec());
            run_op(sz, two, zm, zn, zd, ($urandom % 8 == 0) && zd != zm,
                   "R2 R3 R4 random lookup");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule